// File: doc/BRIEF.md
# Indexed vectored interrupt controller

This block collects up to 128 interrupt inputs and presents a single interrupt request to a processor. Every source has a priority, a trigger kind, an enable bit, a pending bit and a vector. Software reaches these settings through one source-select register and a few shared windows. Mode and vector reads and writes go to whichever source is selected. Command writes enable or disable that source, and they also set or clear its pending bit.

A priority resolver picks the enabled pending source with the highest priority. On a tie, the lowest source number wins. The request output is raised only when that winner outranks the interrupt now being serviced. Reading the acknowledge window returns the winner's vector and pushes the winner onto an 8-entry nesting stack. Writing the end-of-interrupt window pops the stack. When nothing qualifies, the acknowledge window returns a software-programmable spurious vector.

The register bus is a plain 32-bit single-cycle port. Read data is combinational from the address. Write and read side effects take place on the clock edge that ends the access.

Top module: `vic_top`

## Requirements
- R1: After reset every source is disabled, not pending, at priority 0, trigger kind 0 and vector 0. The spurious vector is 0, the stack is empty and `irq_o` is low.
- R2: Offset 0x00 holds the selected source number in its low 7 bits. Offset 0x04 reads and writes the selected source's mode, with priority in bits [2:0] and trigger kind in bits [6:5]; its other bits read 0. Offset 0x08 reads and writes the selected source's 32-bit vector.
- R3: Writing a value with bit 0 set to 0x40 enables the selected source, and the same write to 0x44 disables it. A write with bit 0 clear has no effect. Bit 0 of 0x30 shows the selected source's enable.
- R4: Writing a value with bit 0 set to 0x4c makes the selected source pending, and the same write to 0x48 clears its latched pending bit. Offsets 0x20, 0x24, 0x28 and 0x2c return the pending state of sources n with n/32 = 0..3, at bit n%32.
- R5: Trigger kind 0 is active-high level and kind 1 is active-low level. For these kinds, the pending state follows the input level in addition to any latched pending bit.
- R6: Trigger kind 2 latches pending on a rising input edge and kind 3 on a falling edge. The latched pending bit stays set after the input returns, and it is cleared when the source is acknowledged.
- R7: `irq_o` is high exactly when some enabled pending source has a priority strictly greater than the priority on top of the stack, or when such a source exists and the stack is empty.
- R8: The winner is the enabled pending source of highest priority; among equal priorities, the lowest source number wins.
- R9: Reading 0x10 while `irq_o` is high returns the winner's vector, pushes it onto the stack and clears its latched pending bit. Offset 0x18 then returns its source number.
- R10: Reading 0x10 while `irq_o` is low returns the spurious vector held at 0x3c and leaves the stack unchanged. Offset 0x18 reads 0 while the stack is empty.
- R11: Any write to 0x38 pops the stack. A pop on an empty stack is ignored. The stack holds 8 nested interrupts, so 8 such writes always empty it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_in | input | 128 | Interrupt inputs, synchronous to `clk` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Assertions check several properties on every cycle. A declared winner must really be requesting, and nothing may request unseen. A disable command must leave the source disabled. An acknowledge must clear the latched pending bit and grow the stack with the right entry. A pop on an empty stack must change nothing, and the stack must never be pushed while full. Some behaviour depends on software doing things in order, and only the bench scenarios can show it. These include the readback of the windows for different selections and the level versus edge pending behaviour. They also include tie-breaking by source number across successive acknowledges, eight-deep nesting unwound by end-of-interrupt writes, and the spurious vector returned when nothing outranks the stack top.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the vectored interrupt controller: register
// offsets and the per-source trigger kinds. Assumes a byte-addressed bus.
package vic_pkg;

    typedef enum logic [1:0] {
        KIND_HIGH = 2'd0,
        KIND_LOW  = 2'd1,
        KIND_RISE = 2'd2,
        KIND_FALL = 2'd3
    } trig_kind_t;

    localparam logic [7:0] OFF_SEL   = 8'h00;
    localparam logic [7:0] OFF_MODE  = 8'h04;
    localparam logic [7:0] OFF_VEC   = 8'h08;
    localparam logic [7:0] OFF_ACK   = 8'h10;
    localparam logic [7:0] OFF_STAT  = 8'h18;
    localparam logic [7:0] OFF_PEND0 = 8'h20;
    localparam logic [7:0] OFF_PEND1 = 8'h24;
    localparam logic [7:0] OFF_PEND2 = 8'h28;
    localparam logic [7:0] OFF_PEND3 = 8'h2c;
    localparam logic [7:0] OFF_MASK  = 8'h30;
    localparam logic [7:0] OFF_EOI   = 8'h38;
    localparam logic [7:0] OFF_SPUR  = 8'h3c;
    localparam logic [7:0] OFF_EN    = 8'h40;
    localparam logic [7:0] OFF_DIS   = 8'h44;
    localparam logic [7:0] OFF_CLR   = 8'h48;
    localparam logic [7:0] OFF_SET   = 8'h4c;

endpackage

// File: rtl/vic_srcbank.sv
`timescale 1ns/1ps
// Per-source state: enable, latched pending, priority, trigger kind and
// vector. Commands act on the source named by sel. Assumes irq_in is
// already synchronous to clk.
module vic_srcbank
    import vic_pkg::*;
#(
    parameter int NSRC   = 128,
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 32,
    parameter int ID_W   = $clog2(NSRC)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ID_W-1:0]              sel,
    input  logic                         en_set,
    input  logic                         en_clr,
    input  logic                         pend_set,
    input  logic                         pend_clr,
    input  logic                         mode_we,
    input  logic                         vec_we,
    input  logic [31:0]                  wdata,
    input  logic                         ack_clr,
    input  logic [ID_W-1:0]              ack_id,
    input  logic [NSRC-1:0]              irq_in,
    output logic [NSRC-1:0]              req_o,
    output logic [NSRC-1:0]              pend_o,
    output logic [NSRC-1:0]              en_o,
    output logic [NSRC-1:0][PRIO_W-1:0]  prio_o,
    output logic [NSRC-1:0][1:0]         kind_o,
    output logic [NSRC-1:0][VEC_W-1:0]   vec_o
);

    logic [NSRC-1:0]             en_q, pend_q, in_q, edge_hit, lvl_hit;
    logic [NSRC-1:0][PRIO_W-1:0] prio_q;
    logic [NSRC-1:0][1:0]        kind_q;
    logic [NSRC-1:0][VEC_W-1:0]  vec_q;

    // Detect trigger conditions per source from its kind and input history.
    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            edge_hit[i] = ((kind_q[i] == KIND_RISE) &&  irq_in[i] && !in_q[i]) ||
                          ((kind_q[i] == KIND_FALL) && !irq_in[i] &&  in_q[i]);
            lvl_hit[i]  = ((kind_q[i] == KIND_HIGH) &&  irq_in[i]) ||
                          ((kind_q[i] == KIND_LOW)  && !irq_in[i]);
        end
    end

    // Update enable, pending and input history for every source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            in_q   <= '0;
        end else begin
            in_q <= irq_in;
            for (int i = 0; i < NSRC; i++) begin
                if (sel == ID_W'(i) && en_set)
                    en_q[i] <= 1'b1;
                else if (sel == ID_W'(i) && en_clr)
                    en_q[i] <= 1'b0;
                pend_q[i] <= (pend_set && sel == ID_W'(i)) || edge_hit[i] ||
                             (pend_q[i] && !((pend_clr && sel == ID_W'(i)) ||
                                             (ack_clr && ack_id == ID_W'(i))));
            end
        end
    end

    // Store mode and vector of the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            kind_q <= '0;
            vec_q  <= '0;
        end else begin
            if (mode_we) begin
                prio_q[sel] <= wdata[PRIO_W-1:0];
                kind_q[sel] <= wdata[6:5];
            end
            if (vec_we)
                vec_q[sel] <= wdata[VEC_W-1:0];
        end
    end

    assign pend_o = pend_q | lvl_hit;
    assign req_o  = pend_o & en_q;
    assign en_o   = en_q;
    assign prio_o = prio_q;
    assign kind_o = kind_q;
    assign vec_o  = vec_q;

    // R3
    dis_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_clr && !en_set) |=> !en_q[$past(sel)]);

    // R6
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr && !pend_set && !edge_hit[ack_id]) |=> !pend_q[$past(ack_id)]);

endmodule

// File: rtl/vic_arbiter.sv
`timescale 1ns/1ps
// Priority resolver: picks the requesting source with the highest
// priority, lowest source number on ties. Purely combinational.
module vic_arbiter #(
    parameter int NSRC   = 128,
    parameter int PRIO_W = 3,
    parameter int ID_W   = $clog2(NSRC)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             req,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output logic                        win_valid,
    output logic [ID_W-1:0]             win_id,
    output logic [PRIO_W-1:0]           win_prio
);

    // Scan upward, replacing the candidate only on a strictly higher priority.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (req[i] && (!win_valid || prio[i] > win_prio)) begin
                win_valid = 1'b1;
                win_id    = ID_W'(i);
                win_prio  = prio[i];
            end
        end
    end

    // R8
    win_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (req[win_id] && prio[win_id] == win_prio));

    // R7
    no_hidden_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (req == '0));

endmodule

// File: rtl/vic_stack.sv
`timescale 1ns/1ps
// Nesting stack of acknowledged interrupts (priority and source number).
// Assumes push and pop never arrive in the same cycle; a pop when empty
// is dropped.
module vic_stack #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic [ID_W-1:0]   push_id,
    input  logic              pop,
    output logic              empty,
    output logic              full,
    output logic [PRIO_W-1:0] top_prio,
    output logic [ID_W-1:0]   top_id
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0][PRIO_W-1:0] prio_mem;
    logic [DEPTH-1:0][ID_W-1:0]   id_mem;
    logic [CNT_W-1:0]             cnt, cnt_m1;

    // Track the fill level; a push takes precedence over a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (push && !full)
            cnt <= cnt + CNT_W'(1);
        else if (pop && !empty)
            cnt <= cnt_m1;
    end

    // Write the pushed entry into the free slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_mem <= '0;
            id_mem   <= '0;
        end else if (push && !full) begin
            prio_mem[cnt[PTR_W-1:0]] <= push_prio;
            id_mem[cnt[PTR_W-1:0]]   <= push_id;
        end
    end

    assign cnt_m1   = cnt - CNT_W'(1);
    assign empty    = (cnt == '0);
    assign full     = (cnt == CNT_W'(DEPTH));
    assign top_prio = empty ? '0 : prio_mem[cnt_m1[PTR_W-1:0]];
    assign top_id   = empty ? '0 : id_mem[cnt_m1[PTR_W-1:0]];

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R11
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> empty);

    // R9
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (top_id == $past(push_id) && top_prio == $past(push_prio)));

endmodule

// File: rtl/vic_top.sv
`timescale 1ns/1ps
// Vectored interrupt controller top: register decode, source bank,
// priority resolver and nesting stack. Assumes single-cycle bus accesses
// with combinational read data; side effects occur on the closing edge.
module vic_top
    import vic_pkg::*;
#(
    parameter int NSRC   = 128,
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 32,
    parameter int DEPTH  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic [7:0]      bus_addr,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    input  logic [NSRC-1:0] irq_in,
    output logic            irq_o
);

    localparam int ID_W = $clog2(NSRC);
    localparam int PADW = 128;

    logic                        wr_en, rd_en, ack_rd, grant, eoi;
    logic [ID_W-1:0]             sel_q;
    logic [VEC_W-1:0]            spur_q;
    logic [NSRC-1:0]             req, pend, en;
    logic [NSRC-1:0][PRIO_W-1:0] prio;
    logic [NSRC-1:0][1:0]        kind;
    logic [NSRC-1:0][VEC_W-1:0]  vec;
    logic                        win_valid, stk_empty, stk_full;
    logic [ID_W-1:0]             win_id, top_id;
    logic [PRIO_W-1:0]           win_prio, top_prio;
    logic [PADW-1:0]             pend_pad;
    logic [31:0]                 mode_rd;

    assign wr_en  = bus_sel && bus_wr;
    assign rd_en  = bus_sel && !bus_wr;
    assign ack_rd = rd_en && (bus_addr == OFF_ACK);
    assign grant  = ack_rd && irq_o;
    assign eoi    = wr_en && (bus_addr == OFF_EOI);
    assign irq_o  = win_valid && (stk_empty || win_prio > top_prio);

    // Hold the source selection and the spurious vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            spur_q <= '0;
        end else begin
            if (wr_en && bus_addr == OFF_SEL)
                sel_q <= bus_wdata[ID_W-1:0];
            if (wr_en && bus_addr == OFF_SPUR)
                spur_q <= bus_wdata[VEC_W-1:0];
        end
    end

    vic_srcbank #(.NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .ID_W(ID_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel_q),
        .en_set   (wr_en && bus_addr == OFF_EN  && bus_wdata[0]),
        .en_clr   (wr_en && bus_addr == OFF_DIS && bus_wdata[0]),
        .pend_set (wr_en && bus_addr == OFF_SET && bus_wdata[0]),
        .pend_clr (wr_en && bus_addr == OFF_CLR && bus_wdata[0]),
        .mode_we  (wr_en && bus_addr == OFF_MODE),
        .vec_we   (wr_en && bus_addr == OFF_VEC),
        .wdata    (bus_wdata),
        .ack_clr  (grant),
        .ack_id   (win_id),
        .irq_in   (irq_in),
        .req_o    (req),
        .pend_o   (pend),
        .en_o     (en),
        .prio_o   (prio),
        .kind_o   (kind),
        .vec_o    (vec)
    );

    vic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .prio      (prio),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    vic_stack #(.DEPTH(DEPTH), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (grant),
        .push_prio (win_prio),
        .push_id   (win_id),
        .pop       (eoi),
        .empty     (stk_empty),
        .full      (stk_full),
        .top_prio  (top_prio),
        .top_id    (top_id)
    );

    // Assemble the padded pending vector and the mode readback word.
    always_comb begin
        pend_pad = PADW'(pend);
        mode_rd  = '0;
        mode_rd[PRIO_W-1:0] = prio[sel_q];
        mode_rd[6:5]        = kind[sel_q];
    end

    // Select read data by offset.
    always_comb begin
        unique case (bus_addr)
            OFF_SEL:   bus_rdata = 32'(sel_q);
            OFF_MODE:  bus_rdata = mode_rd;
            OFF_VEC:   bus_rdata = 32'(vec[sel_q]);
            OFF_ACK:   bus_rdata = irq_o ? 32'(vec[win_id]) : 32'(spur_q);
            OFF_STAT:  bus_rdata = 32'(top_id);
            OFF_PEND0: bus_rdata = pend_pad[31:0];
            OFF_PEND1: bus_rdata = pend_pad[63:32];
            OFF_PEND2: bus_rdata = pend_pad[95:64];
            OFF_PEND3: bus_rdata = pend_pad[127:96];
            OFF_MASK:  bus_rdata = {31'b0, en[sel_q]};
            OFF_SPUR:  bus_rdata = 32'(spur_q);
            default:   bus_rdata = '0;
        endcase
    end

    // R9
    ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !stk_empty);

    // R10
    spur_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !irq_o) |=> (stk_empty == $past(stk_empty) && top_id == $past(top_id)));

    // R7
    irq_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (win_valid && !stk_full));

endmodule

// File: tb/sim_vic_top.sv
`timescale 1ns/1ps
// Directed bench for vic_top: one task per scenario, each checking its
// own results through the register bus and the request output.
module sim_vic_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] irq_in = '0;
    logic         irq_o;
    int           n_chk = 0;
    int           n_bad = 0;

    always #10 clk = ~clk;

    vic_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_in    (irq_in),
        .irq_o     (irq_o)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string rq, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(rq, d, exp);
    endtask

    task automatic setup(input int id, input logic [31:0] mode, input logic [31:0] v);
        wr(8'h00, 32'(id));
        wr(8'h04, mode);
        wr(8'h08, v);
        wr(8'h40, 32'h1);
    endtask

    task automatic t_reset();
        chk("R1 irq low", {31'b0, irq_o}, 32'h0);
        rd_chk("R1 ack gives spurious 0", 8'h10, 32'h0);
        rd_chk("R1 status empty", 8'h18, 32'h0);
        rd_chk("R1 pending word0", 8'h20, 32'h0);
        rd_chk("R1 mode src0", 8'h04, 32'h0);
        rd_chk("R1 enable src0", 8'h30, 32'h0);
    endtask

    task automatic t_config();
        wr(8'h00, 32'h85);
        rd_chk("R2 select low 7 bits", 8'h00, 32'h05);
        wr(8'h04, 32'h63);
        wr(8'h08, 32'hA5A5_0005);
        wr(8'h00, 32'h06);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h08, 32'h0000_0006);
        rd_chk("R2 mode src6 masked", 8'h04, 32'h67);
        wr(8'h00, 32'h05);
        rd_chk("R2 mode src5", 8'h04, 32'h63);
        rd_chk("R2 vector src5", 8'h08, 32'hA5A5_0005);
        wr(8'h00, 32'h06);
        wr(8'h04, 32'h0);
    endtask

    task automatic t_enable();
        wr(8'h00, 32'h05);
        wr(8'h40, 32'h1);
        rd_chk("R3 enabled", 8'h30, 32'h1);
        wr(8'h44, 32'h0);
        rd_chk("R3 disable with bit0 clear ignored", 8'h30, 32'h1);
        wr(8'h44, 32'h1);
        rd_chk("R3 disabled", 8'h30, 32'h0);
        wr(8'h40, 32'h2);
        rd_chk("R3 enable with bit0 clear ignored", 8'h30, 32'h0);
    endtask

    task automatic t_swpend();
        wr(8'h00, 32'd40);
        wr(8'h4c, 32'h1);
        rd_chk("R4 set pending src40 word1 bit8", 8'h24, 32'h100);
        chk("R3 disabled source raises nothing", {31'b0, irq_o}, 32'h0);
        wr(8'h00, 32'd127);
        wr(8'h4c, 32'h1);
        rd_chk("R4 src127 word3 bit31", 8'h2c, 32'h8000_0000);
        wr(8'h48, 32'h1);
        wr(8'h00, 32'd40);
        wr(8'h48, 32'h1);
        rd_chk("R4 clear src40", 8'h24, 32'h0);
        rd_chk("R4 clear src127", 8'h2c, 32'h0);
    endtask

    task automatic t_level();
        setup(3, 32'h02, 32'h33);
        @(negedge clk); irq_in[3] = 1'b1;
        #1;
        rd_chk("R5 high level pending", 8'h20, 32'h8);
        chk("R7 irq on level", {31'b0, irq_o}, 32'h1);
        rd_chk("R9 ack vector src3", 8'h10, 32'h33);
        rd_chk("R9 status src3", 8'h18, 32'd3);
        chk("R7 equal priority blocked", {31'b0, irq_o}, 32'h0);
        wr(8'h38, 32'h0);
        chk("R5 level still active after pop", {31'b0, irq_o}, 32'h1);
        @(negedge clk); irq_in[3] = 1'b0;
        #1;
        chk("R5 level dropped", {31'b0, irq_o}, 32'h0);
        wr(8'h44, 32'h1);
        wr(8'h04, 32'h22);
        rd_chk("R5 low level pending at input 0", 8'h20, 32'h8);
        @(negedge clk); irq_in[3] = 1'b1;
        #1;
        rd_chk("R5 low level idle at input 1", 8'h20, 32'h0);
        wr(8'h04, 32'h02);
        @(negedge clk); irq_in[3] = 1'b0;
    endtask

    task automatic t_edge();
        setup(10, 32'h44, 32'h1010);
        @(negedge clk); irq_in[10] = 1'b1;
        @(negedge clk);
        rd_chk("R6 rising edge latched", 8'h20, 32'h400);
        irq_in[10] = 1'b0;
        @(negedge clk);
        rd_chk("R6 pending held after input low", 8'h20, 32'h400);
        chk("R7 irq on edge", {31'b0, irq_o}, 32'h1);
        rd_chk("R9 ack vector src10", 8'h10, 32'h1010);
        rd_chk("R6 ack clears edge pending", 8'h20, 32'h0);
        wr(8'h38, 32'h0);
        setup(11, 32'h64, 32'h1111);
        @(negedge clk); irq_in[11] = 1'b1;
        @(negedge clk);
        rd_chk("R6 falling kind ignores rise", 8'h20, 32'h0);
        irq_in[11] = 1'b0;
        @(negedge clk);
        rd_chk("R6 falling edge latched", 8'h20, 32'h800);
        rd_chk("R9 ack vector src11", 8'h10, 32'h1111);
        wr(8'h38, 32'h0);
        rd_chk("R6 falling pending cleared", 8'h20, 32'h0);
        wr(8'h44, 32'h1);
        wr(8'h00, 32'd10);
        wr(8'h44, 32'h1);
    endtask

    task automatic t_tie();
        for (int k = 20; k <= 22; k++) begin
            setup(k, (k == 22) ? 32'h01 : 32'h05, 32'(k + 12));
            wr(8'h4c, 32'h1);
        end
        chk("R7 irq with pending", {31'b0, irq_o}, 32'h1);
        rd_chk("R8 tie to lowest number", 8'h10, 32'd32);
        rd_chk("R9 status src20", 8'h18, 32'd20);
        chk("R7 equal priority waits", {31'b0, irq_o}, 32'h0);
        wr(8'h38, 32'h0);
        rd_chk("R8 second of tie", 8'h10, 32'd33);
        wr(8'h38, 32'h0);
        rd_chk("R8 lower priority last", 8'h10, 32'd34);
        wr(8'h38, 32'h0);
        chk("R7 nothing left", {31'b0, irq_o}, 32'h0);
        for (int k = 20; k <= 22; k++) begin
            wr(8'h00, 32'(k));
            wr(8'h44, 32'h1);
        end
    endtask

    task automatic t_nest();
        wr(8'h3c, 32'hDEAD);
        rd_chk("R10 spurious when idle", 8'h10, 32'hDEAD);
        rd_chk("R10 status stays empty", 8'h18, 32'h0);
        for (int k = 0; k < 8; k++) begin
            setup(30 + k, 32'(k), 32'(32'h100 + k));
            wr(8'h4c, 32'h1);
            rd_chk("R9 nested ack vector", 8'h10, 32'(32'h100 + k));
            rd_chk("R11 nested status", 8'h18, 32'(30 + k));
        end
        rd_chk("R10 spurious when stack top highest", 8'h10, 32'hDEAD);
        rd_chk("R10 no push on spurious", 8'h18, 32'd37);
        for (int k = 7; k > 0; k--) begin
            wr(8'h38, 32'h0);
            rd_chk("R11 pop status", 8'h18, 32'(29 + k));
        end
        wr(8'h38, 32'hFFFF_FFFF);
        rd_chk("R11 eighth pop empties", 8'h18, 32'h0);
        wr(8'h38, 32'h0);
        rd_chk("R11 pop on empty ignored", 8'h18, 32'h0);
        chk("R11 irq low after unwinding", {31'b0, irq_o}, 32'h0);
        setup(50, 32'h03, 32'h5050);
        wr(8'h4c, 32'h1);
        rd_chk("R11 stack usable after extra pop", 8'h10, 32'h5050);
        rd_chk("R11 status after extra pop", 8'h18, 32'd50);
        wr(8'h38, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_config();
        t_enable();
        t_swpend();
        t_level();
        t_edge();
        t_tie();
        t_nest();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule